// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired controller of a multicycle processor datapath that executes five instruction classes: register-register arithmetic, OR with an immediate, word load, word store and branch on equality. Each instruction takes a chain of clock cycles. The chain always begins with an instruction fetch and a decode step that also loads the operand registers. The controller then walks a chain of states that is specific to the class, and it returns to fetch.

The controller is a Moore machine. Every datapath control point is decoded from the current 4-bit state alone. The opcode is sampled only in the decode state, where it picks the first state of the class chain. The branch outcome is not an input. In the branch state the controller asks for a conditional PC update, and the datapath's own equality register chooses between the target and PC+4. An opcode that no class claims sends the machine back to fetch and raises a one-cycle flag.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset forces state 0000 (fetch) and clears `illegal_op`. This holds even when reset arrives in the middle of an instruction.
- R2: Fetch (0000) always moves to decode (0001). Fetch drives only `ir_load` and `imem_rd`. Decode drives only `opnd_load`.
- R3: In decode the opcode selects the next state: 000000 goes to 0100, 001101 goes to 0110, 100011 goes to 1000, 101011 goes to 1011, and 000100 goes to 0011.
- R4: Register class: 0100 drives `alu_op`=10 (function code), `alu_b_sel`=00 (register) and `res_load`. Then 0101 drives `rf_wr`, `rf_dst_rd`=1 and `pc_en` with `pc_sel`=0 (PC+4). The chain then returns to fetch.
- R5: OR-immediate class: 0110 drives `alu_op`=01 (OR), `alu_b_sel`=01 (zero-extended) and `res_load`. Then 0111 drives `rf_wr` with `rf_dst_rd`=0 and `pc_en`. The chain then returns to fetch.
- R6: Load class: 1000 drives `alu_op`=00 (add), `alu_b_sel`=10 (sign-extended) and `res_load`. Then 1001 drives `dmem_rd` and `mdr_load`. Then 1010 drives `rf_wr`, `rf_src_mem`=1 and `pc_en`. The chain then returns to fetch.
- R7: Store class: 1011 drives add with the sign-extended operand and `res_load`. Then 1100 drives `dmem_wr` and `pc_en`. The chain then returns to fetch.
- R8: Branch state 0011 drives `pc_en` with `pc_sel`=1 (target if equal) and then returns to fetch.
- R9: Fetch to the next fetch takes 3 cycles for branch, 4 for register, OR-immediate and store, and 5 for load.
- R10: An opcode outside the five codes returns decode to fetch. `illegal_op` is then high for exactly the one fetch cycle that follows.
- R11: The opcode has no effect outside decode. Changing it in the middle of a chain leaves the state sequence and all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| state_o | output | 4 | Current state code |
| illegal_op | output | 1 | One-cycle flag for an unrecognised opcode |
| ir_load | output | 1 | Load the instruction register |
| imem_rd | output | 1 | Instruction memory read |
| opnd_load | output | 1 | Load the operand and equality registers |
| alu_op | output | 2 | 00 add, 01 OR, 10 function code |
| alu_b_sel | output | 2 | 00 register, 01 zero-extended, 10 sign-extended |
| res_load | output | 1 | Load the ALU result register |
| dmem_rd | output | 1 | Data memory read |
| dmem_wr | output | 1 | Data memory write |
| mdr_load | output | 1 | Load the memory data register |
| rf_wr | output | 1 | Register file write |
| rf_dst_rd | output | 1 | 1: write rd, 0: write rt |
| rf_src_mem | output | 1 | 1: write data from memory, 0: from ALU result |
| pc_en | output | 1 | PC update |
| pc_sel | output | 1 | 0: PC+4, 1: branch target when operands equal |

## Verification
The bench runs every class and checks the state and the full control word in every cycle. A wrong dispatch code or a swapped chain would then show up at once as a wrong state code. Two different illegal opcodes are sent, one of them a single bit away from a valid code. This catches a flag that lasts two cycles or never rises, and it catches a machine that hangs in decode. The opcode is also flipped in the middle of a chain, which exposes a next-state path that samples it outside decode. A reset in the middle of a load must land in fetch, which exposes a reset that does not cover every state.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

    localparam int ST_W  = 4;
    localparam int OPC_W = 6;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH    = 4'b0000,
        ST_DECODE   = 4'b0001,
        ST_BRANCH   = 4'b0011,
        ST_R_EXEC   = 4'b0100,
        ST_R_WB     = 4'b0101,
        ST_ORI_EXEC = 4'b0110,
        ST_ORI_WB   = 4'b0111,
        ST_LW_ADDR  = 4'b1000,
        ST_LW_MEM   = 4'b1001,
        ST_LW_WB    = 4'b1010,
        ST_SW_ADDR  = 4'b1011,
        ST_SW_MEM   = 4'b1100
    } fsm_state_e;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LW    = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_SW    = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_OR   = 2'b01,
        ALU_FUNC = 2'b10
    } alu_op_e;

    typedef enum logic [1:0] {
        BSEL_REG  = 2'b00,
        BSEL_ZEXT = 2'b01,
        BSEL_SEXT = 2'b10
    } bsel_e;

    typedef enum logic {
        PCSEL_SEQ    = 1'b0,
        PCSEL_BRANCH = 1'b1
    } pc_sel_e;

    typedef struct packed {
        logic    ir_load;
        logic    imem_rd;
        logic    opnd_load;
        alu_op_e alu_op;
        bsel_e   b_sel;
        logic    res_load;
        logic    dmem_rd;
        logic    dmem_wr;
        logic    mdr_load;
        logic    rf_wr;
        logic    rf_dst_rd;
        logic    rf_src_mem;
        logic    pc_en;
        pc_sel_e pc_sel;
    } ctrl_t;

    typedef struct packed {
        logic       hit;
        fsm_state_e target;
    } dispatch_t;

    function automatic ctrl_t ctrl_idle();
        ctrl_t c;
        c = '0;
        return c;
    endfunction

    function automatic dispatch_t lookup_class(input logic [OPC_W-1:0] opc);
        dispatch_t d;
        d.hit    = 1'b1;
        d.target = ST_FETCH;
        unique case (opc)
            OPC_RTYPE: d.target = ST_R_EXEC;
            OPC_ORI:   d.target = ST_ORI_EXEC;
            OPC_LW:    d.target = ST_LW_ADDR;
            OPC_SW:    d.target = ST_SW_ADDR;
            OPC_BEQ:   d.target = ST_BRANCH;
            default:   d.hit    = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mcf_dispatch.sv
module mcf_dispatch
    import mcf_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output dispatch_t        disp
);
    always_comb begin
        disp = lookup_class(opcode);
    end
endmodule

// File: rtl/mcf_seq.sv
module mcf_seq
    import mcf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  dispatch_t  disp,
    output fsm_state_e state,
    output logic       illegal_q
);
    fsm_state_e state_nx;

    always_comb begin
        state_nx = ST_FETCH;
        unique case (state)
            ST_FETCH:    state_nx = ST_DECODE;
            ST_DECODE:   state_nx = disp.hit ? disp.target : ST_FETCH;
            ST_R_EXEC:   state_nx = ST_R_WB;
            ST_ORI_EXEC: state_nx = ST_ORI_WB;
            ST_LW_ADDR:  state_nx = ST_LW_MEM;
            ST_LW_MEM:   state_nx = ST_LW_WB;
            ST_SW_ADDR:  state_nx = ST_SW_MEM;
            default:     state_nx = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_FETCH;
            illegal_q <= 1'b0;
        end else begin
            state     <= state_nx;
            illegal_q <= (state == ST_DECODE) && !disp.hit;
        end
    end
endmodule

// File: rtl/mcf_ctrl_decode.sv
module mcf_ctrl_decode
    import mcf_pkg::*;
(
    input  fsm_state_e state,
    output ctrl_t      ctl
);
    always_comb begin
        ctl = ctrl_idle();
        unique case (state)
            ST_FETCH: begin
                ctl.ir_load = 1'b1;
                ctl.imem_rd = 1'b1;
            end
            ST_DECODE: ctl.opnd_load = 1'b1;
            ST_R_EXEC: begin
                ctl.alu_op   = ALU_FUNC;
                ctl.b_sel    = BSEL_REG;
                ctl.res_load = 1'b1;
            end
            ST_R_WB: begin
                ctl.rf_wr     = 1'b1;
                ctl.rf_dst_rd = 1'b1;
                ctl.pc_en     = 1'b1;
            end
            ST_ORI_EXEC: begin
                ctl.alu_op   = ALU_OR;
                ctl.b_sel    = BSEL_ZEXT;
                ctl.res_load = 1'b1;
            end
            ST_ORI_WB: begin
                ctl.rf_wr = 1'b1;
                ctl.pc_en = 1'b1;
            end
            ST_LW_ADDR, ST_SW_ADDR: begin
                ctl.alu_op   = ALU_ADD;
                ctl.b_sel    = BSEL_SEXT;
                ctl.res_load = 1'b1;
            end
            ST_LW_MEM: begin
                ctl.dmem_rd  = 1'b1;
                ctl.mdr_load = 1'b1;
            end
            ST_LW_WB: begin
                ctl.rf_wr      = 1'b1;
                ctl.rf_src_mem = 1'b1;
                ctl.pc_en      = 1'b1;
            end
            ST_SW_MEM: begin
                ctl.dmem_wr = 1'b1;
                ctl.pc_en   = 1'b1;
            end
            ST_BRANCH: begin
                ctl.pc_en  = 1'b1;
                ctl.pc_sel = PCSEL_BRANCH;
            end
            default: ctl = ctrl_idle();
        endcase
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    output logic [ST_W-1:0]  state_o,
    output logic             illegal_op,
    output logic             ir_load,
    output logic             imem_rd,
    output logic             opnd_load,
    output logic [1:0]       alu_op,
    output logic [1:0]       alu_b_sel,
    output logic             res_load,
    output logic             dmem_rd,
    output logic             dmem_wr,
    output logic             mdr_load,
    output logic             rf_wr,
    output logic             rf_dst_rd,
    output logic             rf_src_mem,
    output logic             pc_en,
    output logic             pc_sel
);
    dispatch_t  disp;
    fsm_state_e state;
    ctrl_t      ctl;

    mcf_dispatch u_disp (
        .opcode (opcode),
        .disp   (disp)
    );

    mcf_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .disp      (disp),
        .state     (state),
        .illegal_q (illegal_op)
    );

    mcf_ctrl_decode u_dec (
        .state (state),
        .ctl   (ctl)
    );

    assign state_o    = state;
    assign ir_load    = ctl.ir_load;
    assign imem_rd    = ctl.imem_rd;
    assign opnd_load  = ctl.opnd_load;
    assign alu_op     = ctl.alu_op;
    assign alu_b_sel  = ctl.b_sel;
    assign res_load   = ctl.res_load;
    assign dmem_rd    = ctl.dmem_rd;
    assign dmem_wr    = ctl.dmem_wr;
    assign mdr_load   = ctl.mdr_load;
    assign rf_wr      = ctl.rf_wr;
    assign rf_dst_rd  = ctl.rf_dst_rd;
    assign rf_src_mem = ctl.rf_src_mem;
    assign pc_en      = ctl.pc_en;
    assign pc_sel     = ctl.pc_sel;
endmodule

// File: rtl/mcf_checker.sv
module mcf_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] state_o,
    input logic       illegal_op,
    input logic       ir_load,
    input logic       dmem_rd,
    input logic       dmem_wr,
    input logic       mdr_load,
    input logic       rf_wr,
    input logic       rf_dst_rd,
    input logic       pc_en,
    input logic       pc_sel
);
    assert_reset_to_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_o == 4'b0000));

    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'b0000) |=> (state_o == 4'b0001));

    assert_fetch_loads_ir_R2: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'b0000) |-> ir_load);

    assert_rwb_controls_R4: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'b0101) |-> (rf_wr && rf_dst_rd && pc_en && !pc_sel));

    assert_lw_mem_read_R6: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'b1001) |-> (dmem_rd && mdr_load && !dmem_wr));

    assert_mem_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(dmem_rd && dmem_wr));

    assert_branch_returns_R8: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'b0011) |=> (state_o == 4'b0000));

    assert_branch_pc_R8: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'b0011) |-> (pc_en && pc_sel));

    assert_illegal_in_fetch_R10: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> (state_o == 4'b0000));

    assert_illegal_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        illegal_op |=> !illegal_op);
endmodule

bind mc_ctrl_fsm mcf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .state_o    (state_o),
    .illegal_op (illegal_op),
    .ir_load    (ir_load),
    .dmem_rd    (dmem_rd),
    .dmem_wr    (dmem_wr),
    .mdr_load   (mdr_load),
    .rf_wr      (rf_wr),
    .rf_dst_rd  (rf_dst_rd),
    .pc_en      (pc_en),
    .pc_sel     (pc_sel)
);

// File: tb/mc_ctrl_fsm_tb_top.sv
`timescale 1ns/1ps
module mc_ctrl_fsm_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b0;
    logic [3:0] state_o;
    logic       illegal_op, ir_load, imem_rd, opnd_load, res_load;
    logic [1:0] alu_op, alu_b_sel;
    logic       dmem_rd, dmem_wr, mdr_load, rf_wr, rf_dst_rd, rf_src_mem, pc_en, pc_sel;

    int applied = 0;
    int errors  = 0;
    bit pend_ill = 1'b0;

    typedef struct {
        logic [3:0] st;
        logic       ill;
        string      tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    always #2 clk = ~clk;

    mc_ctrl_fsm dut_i (
        .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
        .illegal_op(illegal_op), .ir_load(ir_load), .imem_rd(imem_rd),
        .opnd_load(opnd_load), .alu_op(alu_op), .alu_b_sel(alu_b_sel),
        .res_load(res_load), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr),
        .mdr_load(mdr_load), .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd),
        .rf_src_mem(rf_src_mem), .pc_en(pc_en), .pc_sel(pc_sel)
    );

    // Field order: ir imem opnd alu[2] bsel[2] res drd dwr mdr rfw dst src pcen pcsel
    function automatic logic [15:0] exp_ctrl(input logic [3:0] st);
        logic ir, im, op, rs, dr, dw, md, rw, dd, sm, pe, ps;
        logic [1:0] al, bs;
        {ir, im, op, rs, dr, dw, md, rw, dd, sm, pe, ps} = '0;
        al = 2'b00; bs = 2'b00;
        case (st)
            4'b0000: begin ir = 1; im = 1; end
            4'b0001: op = 1;
            4'b0100: begin al = 2'b10; rs = 1; end
            4'b0101: begin rw = 1; dd = 1; pe = 1; end
            4'b0110: begin al = 2'b01; bs = 2'b01; rs = 1; end
            4'b0111: begin rw = 1; pe = 1; end
            4'b1000, 4'b1011: begin bs = 2'b10; rs = 1; end
            4'b1001: begin dr = 1; md = 1; end
            4'b1010: begin rw = 1; sm = 1; pe = 1; end
            4'b1100: begin dw = 1; pe = 1; end
            4'b0011: begin pe = 1; ps = 1; end
            default: ;
        endcase
        return {ir, im, op, al, bs, rs, dr, dw, md, rw, dd, sm, pe, ps};
    endfunction

    function automatic void push(input logic [3:0] st, input logic ill, input string tag);
        exp_item_t it;
        it.st = st; it.ill = ill; it.tag = tag;
        exp_q.push_back(it);
    endfunction

    // Monitor: pops one expected item per cycle, samples at the falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_item_t it;
            logic [15:0] act;
            it  = exp_q.pop_front();
            act = {ir_load, imem_rd, opnd_load, alu_op, alu_b_sel, res_load, dmem_rd,
                   dmem_wr, mdr_load, rf_wr, rf_dst_rd, rf_src_mem, pc_en, pc_sel};
            applied++;
            if (state_o !== it.st) begin
                errors++;
                $display("FAIL %s: state act=%b exp=%b", it.tag, state_o, it.st);
            end
            applied++;
            if (act !== exp_ctrl(it.st)) begin
                errors++;
                $display("FAIL %s: ctrl in state %b act=%b exp=%b", it.tag, it.st, act, exp_ctrl(it.st));
            end
            applied++;
            if (illegal_op !== it.ill) begin
                errors++;
                $display("FAIL %s: illegal_op act=%b exp=%b", it.tag, illegal_op, it.ill);
            end
        end
    end

    // Driver: one instruction, fetch to next fetch; garble flips opcode after decode (R11)
    task automatic run_instr(input logic [5:0] opc, input bit garble, input string tag);
        logic [3:0] seq[5];
        int n;
        case (opc)
            6'b000000: begin n = 4; seq[2] = 4'b0100; seq[3] = 4'b0101; end        // R4
            6'b001101: begin n = 4; seq[2] = 4'b0110; seq[3] = 4'b0111; end        // R5
            6'b100011: begin n = 5; seq[2] = 4'b1000; seq[3] = 4'b1001; seq[4] = 4'b1010; end // R6
            6'b101011: begin n = 4; seq[2] = 4'b1011; seq[3] = 4'b1100; end        // R7
            6'b000100: begin n = 3; seq[2] = 4'b0011; end                          // R8
            default:   n = 2;                                                      // R10
        endcase
        seq[0] = 4'b0000;
        seq[1] = 4'b0001;
        for (int i = 0; i < n; i++) begin
            push(seq[i], (i == 0) ? pend_ill : 1'b0, tag);
        end
        pend_ill = (n == 2);
        opcode   = opc;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (garble && i == 1) opcode = ~opc;
        end
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        $display("FAIL watchdog: act=timeout exp=completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

    initial begin
        push(4'b0000, 1'b0, "R1 reset state");
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        run_instr(6'b000000, 0, "R3 R4 R9 rtype");
        run_instr(6'b001101, 0, "R3 R5 R9 ori");
        run_instr(6'b100011, 0, "R3 R6 R9 load");
        run_instr(6'b101011, 0, "R3 R7 R9 store");
        run_instr(6'b000100, 0, "R3 R8 R9 branch");
        run_instr(6'b111111, 0, "R10 illegal all-ones");
        run_instr(6'b000000, 0, "R10 flag after illegal");
        run_instr(6'b000101, 0, "R10 near-branch illegal");
        run_instr(6'b100011, 0, "R10 flag then load");
        run_instr(6'b000000, 1, "R11 rtype opcode flipped");
        run_instr(6'b100011, 1, "R11 load opcode flipped");
        run_instr(6'b000100, 1, "R11 branch opcode flipped");
        run_instr(6'b001101, 1, "R11 ori opcode flipped");
        // R1: reset in the middle of a load
        opcode = 6'b100011;
        push(4'b0000, 1'b0, "R1 pre-reset fetch");
        push(4'b0001, 1'b0, "R1 pre-reset decode");
        push(4'b1000, 1'b0, "R1 pre-reset addr");
        repeat (3) begin @(posedge clk); #1; end
        rst = 1'b1;
        @(posedge clk); #1;
        push(4'b0000, 1'b0, "R1 mid-chain reset");
        @(posedge clk); #1;
        rst = 1'b0;
        run_instr(6'b101011, 0, "R1 R2 store after reset");
        run_instr(6'b110011, 0, "R10 illegal at end");
        push(4'b0000, 1'b1, "R10 final flag");
        @(posedge clk); #1;
        push(4'b0001, 1'b0, "R10 flag cleared R2");
        @(negedge clk); #1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

endmodule